// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register interface that a host processor uses to reach a serial port. Each request on the 16-bit peripheral bus carries a byte offset and an access size. The block decodes twelve registers placed four bytes apart. It holds the configuration registers: the two divisor halves, global control, line control, modem control and a scratch word. It also holds the interrupt-enable word, which can only be changed through a set alias and a clear alias.

Status bits that the serial core reports as one-cycle events are kept as sticky bits until software writes ones to clear them. On every read they are merged with the level signals that the core drives. A write to the transmit holding address hands the byte to the core over a push strobe. A read of the receive buffer address returns the core's current byte and sends back a pop strobe.

Every request gets a response one cycle later. An access that is not 16 bits wide is rejected first. An access to an unmapped offset is rejected next. A rejected access changes nothing.

Top module: `sio_csr_front`

## Requirements
- R1: After reset, the divisor-low word (0x00) reads 0x0001 and every other storage register reads 0x0000. All sticky status bits are clear, so with the transmit-empty and idle inputs high and the receive-ready input low, the line status word (0x14) reads 0x0060.
- R2: Offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x1C (divisor low, divisor high, global control, line control, modem control, scratch) store all 16 written bits and read them back. The first five also drive their configuration output ports.
- R3: A write to 0x20 ORs the written value into the enable word. A write to 0x24 clears every enable bit written as 1. A read of either address returns the enable word, which is also driven on `int_enable`.
- R4: A read of 0x14 returns receive-ready in bit 0, overrun in bit 1, parity in bit 2, framing in bit 3, break in bit 4, transmit-holding-empty in bit 5, transmitter-idle in bit 6 and transmit-finished in bit 7, with bits 15:8 zero. Bits 0, 5 and 6 are the live inputs at the request edge.
- R5: A write to 0x14 clears only those sticky bits (1, 2, 3, 4, 7) that are written as 1. The live bits are not affected. When a set pulse and a clearing write for the same bit arrive in the same cycle, the bit stays set.
- R6: At 0x18, bit 0 is a sticky CTS-change flag set by `cts_change` and cleared by writing 1 to bit 0. Bit 4 reads the live `cts_level`. All other bits read 0, and no other written bit has any effect.
- R7: A write to 0x28 puts the low byte on `tx_data` and raises `tx_push` for exactly the response cycle. `tx_irq` pulses in the same cycle only when enable bit 1 was set. A read of 0x28 returns the last written 16-bit value.
- R8: A read of 0x2C returns `rx_data` (zero-extended) as sampled at the request edge, and raises `rx_pop` for the response cycle. A write to 0x2C produces no pop, no push and no error.
- R9: A size code other than 1 (16-bit) sets `resp_err_size` only, at any address, returns rdata 0 and has no side effect.
- R10: A correctly sized access to an offset with nonzero low two bits, or at 0x30 or above, sets `resp_err_addr` only, returns rdata 0 and has no side effect.
- R11: `resp_valid` is high in exactly the cycle after each accepted request cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 2 | Access size code, 1 = 16-bit |
| bus_wdata | input | 16 | Write data |
| resp_valid | output | 1 | Response strobe |
| resp_rdata | output | 16 | Read data, zero on writes and errors |
| resp_err_size | output | 1 | Access width error |
| resp_err_addr | output | 1 | Unmapped offset error |
| div_lo | output | 16 | Divisor low word |
| div_hi | output | 16 | Divisor high word |
| gctl | output | 16 | Global control word |
| lcr | output | 16 | Line control word |
| mcr | output | 16 | Modem control word |
| int_enable | output | 16 | Interrupt-enable word |
| tx_data | output | 8 | Byte for the transmitter |
| tx_push | output | 1 | Transmit byte strobe |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_data | input | 8 | Current received byte |
| rx_pop | output | 1 | Receive byte consumed |
| rx_ready | input | 1 | Live receive-data-ready |
| thr_empty | input | 1 | Live transmit-holding-empty |
| tx_idle | input | 1 | Live transmitter-empty |
| oe_pulse | input | 1 | Overrun event |
| pe_pulse | input | 1 | Parity event |
| fe_pulse | input | 1 | Framing event |
| bi_pulse | input | 1 | Break event |
| tfi_pulse | input | 1 | Transmit-finished event |
| cts_level | input | 1 | Live CTS |
| cts_change | input | 1 | CTS change event |

## Verification
Corrupted storage or enable state shows on the configuration ports at the edge after the write that caused it, and on the very next readback. A sticky bit that was lost or kept too long shows only when the line status word or the modem status word is read, so the bench reads them right after every set event and every clearing write. A decoder fault is different. It appears as a wrong error flag, a stray push or pop, or changed register contents in the response cycle of a rejected access. For that reason every offset is swept with every size code, and all registers are read back afterwards.

// File: rtl/sio_csr_pkg.sv
package sio_csr_pkg;
  localparam int DW    = 16;
  localparam int NREG  = 12;
  // register slot indices (offset = index * 4)
  localparam int RI_DLL   = 0;
  localparam int RI_DLH   = 1;
  localparam int RI_GCTL  = 2;
  localparam int RI_LCR   = 3;
  localparam int RI_MCR   = 4;
  localparam int RI_LSR   = 5;
  localparam int RI_MSR   = 6;
  localparam int RI_SCR   = 7;
  localparam int RI_IESET = 8;
  localparam int RI_IECLR = 9;
  localparam int RI_THR   = 10;
  localparam int RI_RBR   = 11;
  // access size code accepted
  localparam logic [1:0] SZ_HALF = 2'd1;
  // line status bit positions
  localparam int LB_DR   = 0;
  localparam int LB_OE   = 1;
  localparam int LB_PE   = 2;
  localparam int LB_FE   = 3;
  localparam int LB_BI   = 4;
  localparam int LB_THRE = 5;
  localparam int LB_TEMT = 6;
  localparam int LB_TFI  = 7;
  // enable bit gating the transmit interrupt
  localparam int IE_TX   = 1;
  // sticky line-status vector: {tfi, bi, fe, pe, oe}
  localparam int NSTICKY = 5;
  // plain storage registers
  localparam int NPLAIN  = 6;

  function automatic int plain_slot(input int k);
    case (k)
      0:       return RI_DLL;
      1:       return RI_DLH;
      2:       return RI_GCTL;
      3:       return RI_LCR;
      4:       return RI_MCR;
      default: return RI_SCR;
    endcase
  endfunction
endpackage

// File: rtl/sio_csr_decode.sv
module sio_csr_decode
  import sio_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [NREG-1:0]   sel,
  output logic              err_size,
  output logic              err_addr
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             in_range;
  logic             size_ok;
  logic             hit;

  always_comb begin
    idx      = addr[ADDR_W-1:2];
    aligned  = (addr[1:0] == 2'b00);
    in_range = (idx < IDX_W'(NREG));
    size_ok  = (size == SZ_HALF);
    hit      = req && size_ok && aligned && in_range;
    // width error has priority over address error
    err_size = req && !size_ok;
    err_addr = req && size_ok && !(aligned && in_range);
    for (int k = 0; k < NREG; k++) begin
      sel[k] = hit && (idx == IDX_W'(k));
    end
  end
endmodule

// File: rtl/sio_csr_sticky.sv
module sio_csr_sticky #(
  parameter int           N   = 1,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;

  // set dominates a same-cycle clear
  always_comb q_d = (q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_d;
  end
endmodule

// File: rtl/sio_csr_plain.sv
module sio_csr_plain #(
  parameter int             N   = 6,
  parameter int             W   = 16,
  parameter logic [N*W-1:0] RST = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        we,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic [W-1:0] r_q;
    logic [W-1:0] r_d;

    always_comb r_d = we[g] ? wdata : r_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= RST[g*W +: W];
      else        r_q <= r_d;
    end

    assign q[g] = r_q;
  end
endmodule

// File: rtl/sio_csr_front.sv
module sio_csr_front
  import sio_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic              resp_valid,
  output logic [15:0]       resp_rdata,
  output logic              resp_err_size,
  output logic              resp_err_addr,
  output logic [15:0]       div_lo,
  output logic [15:0]       div_hi,
  output logic [15:0]       gctl,
  output logic [15:0]       lcr,
  output logic [15:0]       mcr,
  output logic [15:0]       int_enable,
  output logic [7:0]        tx_data,
  output logic              tx_push,
  output logic              tx_irq,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  input  logic              rx_ready,
  input  logic              thr_empty,
  input  logic              tx_idle,
  input  logic              oe_pulse,
  input  logic              pe_pulse,
  input  logic              fe_pulse,
  input  logic              bi_pulse,
  input  logic              tfi_pulse,
  input  logic              cts_level,
  input  logic              cts_change
);
  localparam logic [NPLAIN*DW-1:0] PLAIN_RST = {{((NPLAIN-1)*DW){1'b0}}, 16'h0001};

  // decode
  logic [NREG-1:0] sel;
  logic            dec_err_size;
  logic            dec_err_addr;

  sio_csr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .req      (bus_req),
    .addr     (bus_addr),
    .size     (bus_size),
    .sel      (sel),
    .err_size (dec_err_size),
    .err_addr (dec_err_addr)
  );

  logic [NREG-1:0] wsel;
  logic [NREG-1:0] rsel;
  always_comb begin
    wsel = bus_we  ? sel : '0;
    rsel = !bus_we ? sel : '0;
  end

  // plain storage
  logic [NPLAIN-1:0]         plain_we;
  logic [NPLAIN-1:0][DW-1:0] plain_q;

  always_comb begin
    for (int k = 0; k < NPLAIN; k++) plain_we[k] = wsel[plain_slot(k)];
  end

  sio_csr_plain #(.N(NPLAIN), .W(DW), .RST(PLAIN_RST)) plain_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (plain_we),
    .wdata (bus_wdata),
    .q     (plain_q)
  );

  // sticky line status: {tfi, bi, fe, pe, oe}
  logic [NSTICKY-1:0] lsr_set;
  logic [NSTICKY-1:0] lsr_clr;
  logic [NSTICKY-1:0] lsr_sticky_q;

  always_comb begin
    lsr_set = {tfi_pulse, bi_pulse, fe_pulse, pe_pulse, oe_pulse};
    lsr_clr = wsel[RI_LSR] ? {bus_wdata[LB_TFI], bus_wdata[LB_BI], bus_wdata[LB_FE],
                              bus_wdata[LB_PE], bus_wdata[LB_OE]} : '0;
  end

  sio_csr_sticky #(.N(NSTICKY), .RST('0)) lsr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (lsr_set),
    .clr   (lsr_clr),
    .q     (lsr_sticky_q)
  );

  // sticky modem status change flag
  logic scts_clr;
  logic scts_q;
  always_comb scts_clr = wsel[RI_MSR] && bus_wdata[0];

  sio_csr_sticky #(.N(1), .RST(1'b0)) msr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (cts_change),
    .clr   (scts_clr),
    .q     (scts_q)
  );

  // enable word, transmit holding copy
  logic [DW-1:0] ier_q, ier_d;
  logic [DW-1:0] thr_q, thr_d;

  always_comb begin
    ier_d = ier_q;
    if (wsel[RI_IESET])      ier_d = ier_q | bus_wdata;
    else if (wsel[RI_IECLR]) ier_d = ier_q & ~bus_wdata;
    thr_d = wsel[RI_THR] ? bus_wdata : thr_q;
  end

  // read mux
  logic [DW-1:0] lsr_view;
  logic [DW-1:0] msr_view;
  logic [DW-1:0] rd_val;

  always_comb begin
    lsr_view          = '0;
    lsr_view[LB_DR]   = rx_ready;
    lsr_view[LB_OE]   = lsr_sticky_q[0];
    lsr_view[LB_PE]   = lsr_sticky_q[1];
    lsr_view[LB_FE]   = lsr_sticky_q[2];
    lsr_view[LB_BI]   = lsr_sticky_q[3];
    lsr_view[LB_THRE] = thr_empty;
    lsr_view[LB_TEMT] = tx_idle;
    lsr_view[LB_TFI]  = lsr_sticky_q[4];
    msr_view          = '0;
    msr_view[0]       = scts_q;
    msr_view[4]       = cts_level;

    rd_val = '0;
    for (int k = 0; k < NPLAIN; k++) begin
      if (rsel[plain_slot(k)]) rd_val = rd_val | plain_q[k];
    end
    if (rsel[RI_LSR])                  rd_val = rd_val | lsr_view;
    if (rsel[RI_MSR])                  rd_val = rd_val | msr_view;
    if (rsel[RI_IESET] | rsel[RI_IECLR]) rd_val = rd_val | ier_q;
    if (rsel[RI_THR])                  rd_val = rd_val | thr_q;
    if (rsel[RI_RBR])                  rd_val = rd_val | {8'h00, rx_data};
  end

  // response and strobe next state
  logic          resp_valid_d;
  logic [DW-1:0] resp_rdata_d;
  logic          resp_err_size_d;
  logic          resp_err_addr_d;
  logic          tx_push_d;
  logic          tx_irq_d;
  logic          rx_pop_d;

  always_comb begin
    resp_valid_d    = bus_req;
    resp_rdata_d    = rd_val;
    resp_err_size_d = dec_err_size;
    resp_err_addr_d = dec_err_addr;
    tx_push_d       = wsel[RI_THR];
    tx_irq_d        = wsel[RI_THR] && ier_q[IE_TX];
    rx_pop_d        = rsel[RI_RBR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q         <= '0;
      thr_q         <= '0;
      resp_valid    <= 1'b0;
      resp_rdata    <= '0;
      resp_err_size <= 1'b0;
      resp_err_addr <= 1'b0;
      tx_push       <= 1'b0;
      tx_irq        <= 1'b0;
      rx_pop        <= 1'b0;
    end else begin
      ier_q         <= ier_d;
      thr_q         <= thr_d;
      resp_valid    <= resp_valid_d;
      resp_rdata    <= resp_rdata_d;
      resp_err_size <= resp_err_size_d;
      resp_err_addr <= resp_err_addr_d;
      tx_push       <= tx_push_d;
      tx_irq        <= tx_irq_d;
      rx_pop        <= rx_pop_d;
    end
  end

  // outputs
  always_comb begin
    div_lo     = plain_q[0];
    div_hi     = plain_q[1];
    gctl       = plain_q[2];
    lcr        = plain_q[3];
    mcr        = plain_q[4];
    int_enable = ier_q;
    tx_data    = thr_q[7:0];
  end
endmodule

// File: rtl/sio_csr_front_chk.sv
module sio_csr_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic        resp_valid,
  input logic        resp_err_size,
  input logic        resp_err_addr,
  input logic        tx_push,
  input logic        tx_irq,
  input logic        rx_pop,
  input logic        oe_pulse,
  input logic        bi_pulse,
  input logic [4:0]  lsr_sticky_q,
  input logic [15:0] div_lo
);
  a_r11_resp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> resp_valid);
  a_r11_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !resp_valid);
  a_r9_errs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_err_size, resp_err_addr}));
  a_r10_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_err_size || resp_err_addr) |-> (!tx_push && !rx_pop));
  a_r7_irq_with_push: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_push);
  a_r5_oe_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    oe_pulse |=> lsr_sticky_q[0]);
  a_r5_bi_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    bi_pulse |=> lsr_sticky_q[3]);
  a_r8_pop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (resp_valid && $past(!bus_we)));
  a_r2_div_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> $stable(div_lo));
endmodule

bind sio_csr_front sio_csr_front_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req       (bus_req),
  .bus_we        (bus_we),
  .resp_valid    (resp_valid),
  .resp_err_size (resp_err_size),
  .resp_err_addr (resp_err_addr),
  .tx_push       (tx_push),
  .tx_irq        (tx_irq),
  .rx_pop        (rx_pop),
  .oe_pulse      (oe_pulse),
  .bi_pulse      (bi_pulse),
  .lsr_sticky_q  (lsr_sticky_q),
  .div_lo        (div_lo)
);

// File: tb/sio_csr_front_tb_top.sv
module sio_csr_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd1;
  logic [15:0] bus_wdata = '0;
  logic        resp_valid, resp_err_size, resp_err_addr;
  logic [15:0] resp_rdata, div_lo, div_hi, gctl, lcr, mcr, int_enable;
  logic [7:0]  tx_data;
  logic        tx_push, tx_irq, rx_pop;
  logic [7:0]  rx_data = '0;
  logic        rx_ready = 1'b0, thr_empty = 1'b1, tx_idle = 1'b1;
  logic        oe_pulse = 0, pe_pulse = 0, fe_pulse = 0, bi_pulse = 0, tfi_pulse = 0;
  logic        cts_level = 0, cts_change = 0;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // sampled response
  logic [15:0] s_data;
  logic        s_valid, s_es, s_ea, s_push, s_irq, s_pop;
  logic [7:0]  s_txd;

  // model of storage (plain order: dll, dlh, gctl, lcr, mcr, scr)
  logic [15:0] m_plain [6];
  logic [15:0] m_ier;
  logic [15:0] m_thr;

  always #4 clk = ~clk;

  sio_csr_front #(.ADDR_W(8)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [7:0] a, input logic [1:0] sz,
                     input logic [15:0] wd, input logic [4:0] pulses);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    {tfi_pulse, bi_pulse, fe_pulse, pe_pulse, oe_pulse} = pulses;
    @(posedge clk);
    #1;
    s_data = resp_rdata; s_valid = resp_valid; s_es = resp_err_size; s_ea = resp_err_addr;
    s_push = tx_push; s_irq = tx_irq; s_pop = rx_pop; s_txd = tx_data;
    bus_req = 1'b0; bus_we = 1'b0;
    {tfi_pulse, bi_pulse, fe_pulse, pe_pulse, oe_pulse} = 5'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    acc(1'b0, a, 2'd1, 16'h0, 5'b0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    acc(1'b1, a, 2'd1, d, 5'b0);
  endtask

  function automatic logic [7:0] plain_off(input int k);
    return (k == 5) ? 8'h1C : 8'(k * 4);
  endfunction

  task automatic readback_all(input string req);
    for (int k = 0; k < 6; k++) begin
      rd(plain_off(k));
      chk(req, s_data, m_plain[k]);
    end
    rd(8'h20); chk(req, s_data, m_ier);
    rd(8'h28); chk(req, s_data, m_thr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    for (int k = 0; k < 6; k++) m_plain[k] = (k == 0) ? 16'h0001 : 16'h0000;
    m_ier = '0; m_thr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk("R1 div_lo port", div_lo, 16'h0001);
    chk("R11 idle resp_valid", resp_valid, 1'b0);
    for (int r = 0; r < 12; r++) begin
      rd(8'(r * 4));
      chk("R1 reset read", s_data, (r == 0) ? 16'h0001 : (r == 5) ? 16'h0060 : 16'h0000);
      chk("R11 resp_valid", s_valid, 1'b1);
    end

    // R2 plain storage sweep
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 6; k++) begin
        pat = 16'(((p * 16'h3C5A) ^ (k * 16'h1111)) + p);
        if (p == 3) pat = 16'hFFFF;
        wr(plain_off(k), pat);
        m_plain[k] = pat;
      end
      for (int k = 0; k < 6; k++) begin
        rd(plain_off(k));
        chk("R2 readback", s_data, m_plain[k]);
      end
      chk("R2 div_lo", div_lo, m_plain[0]);
      chk("R2 div_hi", div_hi, m_plain[1]);
      chk("R2 gctl", gctl, m_plain[2]);
      chk("R2 lcr", lcr, m_plain[3]);
      chk("R2 mcr", mcr, m_plain[4]);
    end

    // R3 enable set / clear aliases
    wr(8'h20, 16'h0005); rd(8'h20); chk("R3 set", s_data, 16'h0005);
    wr(8'h20, 16'h0102); rd(8'h24); chk("R3 set or", s_data, 16'h0107);
    wr(8'h24, 16'h0004); rd(8'h20); chk("R3 clear", s_data, 16'h0103);
    chk("R3 int_enable", int_enable, 16'h0103);
    m_ier = 16'h0103;

    // R4 / R5 line status merge and write-one-to-clear
    acc(1'b0, 8'h30, 2'd1, 16'h0, 5'b00101); // unmapped read carrying oe+fe pulses
    rx_ready = 1'b1; thr_empty = 1'b0; tx_idle = 1'b0;
    rd(8'h14); chk("R4 merge", s_data, 16'h000B);
    wr(8'h14, 16'hFF02); rd(8'h14); chk("R5 clear oe only", s_data, 16'h0009);
    acc(1'b1, 8'h14, 2'd1, 16'hFFFF, 5'b01000); // bi set with full clear
    rd(8'h14); chk("R5 set wins", s_data, 16'h0011);
    wr(8'h14, 16'h0010); rd(8'h14); chk("R5 bi cleared", s_data, 16'h0001);
    acc(1'b0, 8'h00, 2'd1, 16'h0, 5'b10110); // tfi, fe, pe
    thr_empty = 1'b1; tx_idle = 1'b1; rx_ready = 1'b0;
    rd(8'h14); chk("R4 all positions", s_data, 16'h00EC);
    wr(8'h14, 16'h0084); rd(8'h14); chk("R5 partial clear", s_data, 16'h0068);
    wr(8'h14, 16'h0008); rd(8'h14); chk("R5 back to reset", s_data, 16'h0060);

    // R6 modem status
    @(negedge clk); cts_change = 1'b1; cts_level = 1'b1;
    @(negedge clk); cts_change = 1'b0;
    rd(8'h18); chk("R6 scts+cts", s_data, 16'h0011);
    wr(8'h18, 16'hFFFE); rd(8'h18); chk("R6 ignored bits", s_data, 16'h0011);
    wr(8'h18, 16'h0001); rd(8'h18); chk("R6 w1c", s_data, 16'h0010);
    cts_level = 1'b0;

    // R7 transmit path
    wr(8'h28, 16'h12AB); m_thr = 16'h12AB;
    chk("R7 push", s_push, 1'b1); chk("R7 irq on", s_irq, 1'b1); chk("R7 data", s_txd, 8'hAB);
    rd(8'h28); chk("R7 thr readback", s_data, 16'h12AB);
    chk("R7 push one cycle", s_push, 1'b0);
    wr(8'h24, 16'h0002); m_ier = 16'h0101;
    wr(8'h28, 16'h0034); m_thr = 16'h0034;
    chk("R7 push2", s_push, 1'b1); chk("R7 irq off", s_irq, 1'b0); chk("R7 data2", s_txd, 8'h34);

    // R8 receive path
    rx_data = 8'h5E;
    rd(8'h2C); chk("R8 rx data", s_data, 16'h005E); chk("R8 pop", s_pop, 1'b1);
    wr(8'h2C, 16'hFFFF);
    chk("R8 write no pop", s_pop, 1'b0); chk("R8 write no push", s_push, 1'b0);
    chk("R8 write no err", {s_es, s_ea}, 2'b00);
    readback_all("R8 write no effect");

    // R9 / R10 read sweep over all offsets and sizes
    for (int a = 0; a < 256; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic e_s, e_a;
        e_s = (sz != 1);
        e_a = !e_s && !((a % 4 == 0) && (a < 48));
        acc(1'b0, 8'(a), 2'(sz), 16'h0, 5'b0);
        chk("R9 size err", s_es, e_s);
        chk("R10 addr err", s_ea, e_a);
        chk("R8 pop decode", s_pop, (!e_s && !e_a && a == 8'h2C));
        if (e_s || e_a) chk("R10 rdata zero", s_data, 16'h0000);
      end
    end

    // R9 / R10 rejected writes have no side effect
    for (int a = 0; a < 256; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        if (sz != 1 || !((a % 4 == 0) && (a < 48))) begin
          acc(1'b1, 8'(a), 2'(sz), 16'hFFFF, 5'b0);
          chk("R9 no push on rejected write", s_push, 1'b0);
        end
      end
    end
    readback_all("R10 rejected writes");
    rd(8'h14); chk("R9 lsr untouched", s_data, 16'h0060);

    // R11 idle cycle gives no response
    @(negedge clk); @(negedge clk);
    chk("R11 idle", resp_valid, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule